// File: doc/BRIEF.md
# Programmable Clock Divider Channel with Stop

This block is one channel of a clock generator. It takes a set of parent clock-enable tick streams that all share one system clock. It picks one of them and divides it by a programmable ratio from 1 to 64. The result is a stream of single-cycle enable pulses for downstream logic. The channel's output can be stopped and restarted. Because every parent is a tick in the same clock domain, switching parents never produces a runt pulse.

Software controls the channel through one control word. A synchronous write port takes an operation code and write data. Full-word writes are supported, and so are field operations that change only one field and leave all other bits alone. A read-back port always shows the stored word. The channel keeps one known quirk: if the divide field is zero, the stop bit is stored but has no effect. The halt operation therefore also sets the divide field to all ones, so the stop always takes effect. Parent indices that are out of range are rejected and reported with a flag.

Top module: `clkdiv_chan`

## Requirements
- R1: After reset the control word reads 0x0000_013F (stop bit 8 set, divide field [5:0] all ones, parent select 0), en_o is low and sel_err_o is low.
- R2: While running with divide field value n, en_o pulses for one cycle once per n+1 ticks of the selected parent. Each pulse appears in the cycle after the edge that samples the tick completing the period.
- R3: While bit 8 (stop) is 1 and the divide field is non-zero, en_o stays low.
- R4: While the divide field is zero, a stop bit of 1 is ignored: en_o pulses on every selected parent tick. The stop bit still reads back as 1.
- R5: Op 4 (halt) sets bit 8 and sets the divide field to all ones. All other bits keep their values.
- R6: Only ticks of the parent whose index is in the select field (bits [SRC_SHIFT+SRC_W-1:SRC_SHIFT], default [13:12]) advance the divider.
- R7: A parent index of NUM_PARENTS or more, written by op 0 (full write) or op 2 (set parent), leaves the select field unchanged. sel_err_o is high for the one cycle after that write.
- R8: Op 1 (set divide) writes only bits [5:0] from wdata_i[5:0]. Op 2 writes only the select field from wdata_i[SRC_W-1:0]. Op 3 (start) clears only bit 8. Op 0 writes the whole word. rdata_o shows the stored word in the cycle after each write.
- R9: A new divide value written while the channel runs takes effect only after the current period completes.
- R10: When the stop is released, counting begins with a fresh period, so the first pulse comes after exactly n+1 selected ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one operation |
| op_i | input | 3 | Operation: 0 write, 1 set divide, 2 set parent, 3 start, 4 halt |
| wdata_i | input | REG_W | Write data |
| parent_tick_i | input | NUM_PARENTS | Tick stream of each parent clock |
| rdata_o | output | REG_W | Stored control word |
| en_o | output | 1 | Divided enable pulse |
| sel_err_o | output | 1 | Rejected parent index, one cycle |

## Verification
Some properties are checked on every cycle by the assertions. While the output is effectively stopped, no pulse is emitted. Every pulse follows a sampled parent tick. The counter never passes its latched limit. The stored parent index is always in range. A halt always leaves the stop bit set and the divide field full. A divide-field operation never disturbs the other bits. Other behaviours can only be shown by the bench's scenarios. These are the exact pulse counts per window for several ratios and parents. They also include the deferred effect of a ratio change in the middle of a period, the zero-divide stop quirk, and the read-back values after each kind of field operation.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_W    = 6;
  localparam int STOP_BIT = 8;

  typedef enum logic [2:0] {
    OP_WRITE   = 3'd0,
    OP_SET_DIV = 3'd1,
    OP_SET_SRC = 3'd2,
    OP_START   = 3'd3,
    OP_HALT    = 3'd4
  } op_e;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SRC_SHIFT   = 12,
  parameter int SRC_W       = 2,
  parameter int NUM_PARENTS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       op_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] reg_o,
  output logic [DIV_W-1:0] div_o,
  output logic [SRC_W-1:0] src_o,
  output logic             run_o,
  output logic             sel_err_o
);
  localparam logic [REG_W-1:0] DIV_MASK  = REG_W'((1 << DIV_W) - 1);
  localparam logic [REG_W-1:0] STOP_MASK = REG_W'(1) << STOP_BIT;
  localparam logic [REG_W-1:0] SRC_MASK  = REG_W'((1 << SRC_W) - 1) << SRC_SHIFT;
  localparam logic [REG_W-1:0] RST_VAL   = STOP_MASK | DIV_MASK;

  logic [REG_W-1:0] reg_q, reg_d;
  logic             err_q, err_d;
  logic [SRC_W-1:0] full_src, op_src;
  op_e              op;

  assign op       = op_e'(op_i);
  assign full_src = wdata_i[SRC_SHIFT +: SRC_W];
  assign op_src   = wdata_i[SRC_W-1:0];

  always_comb begin
    reg_d = reg_q;
    err_d = 1'b0;
    if (wr_en_i) begin
      case (op)
        OP_WRITE: begin
          reg_d = wdata_i;
          if (int'(full_src) >= NUM_PARENTS) begin
            reg_d = (wdata_i & ~SRC_MASK) | (reg_q & SRC_MASK);
            err_d = 1'b1;
          end
        end
        OP_SET_DIV: reg_d = (reg_q & ~DIV_MASK) | (wdata_i & DIV_MASK);
        OP_SET_SRC: begin
          if (int'(op_src) >= NUM_PARENTS) err_d = 1'b1;
          else reg_d = (reg_q & ~SRC_MASK) | (REG_W'(op_src) << SRC_SHIFT);
        end
        OP_START: reg_d = reg_q & ~STOP_MASK;
        OP_HALT:  reg_d = reg_q | STOP_MASK | DIV_MASK;
        default:  reg_d = reg_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= RST_VAL;
      err_q <= 1'b0;
    end else begin
      reg_q <= reg_d;
      err_q <= err_d;
    end
  end

  assign reg_o     = reg_q;
  assign div_o     = reg_q[DIV_W-1:0];
  assign src_o     = reg_q[SRC_SHIFT +: SRC_W];
  // stop is ignored with a zero divide field
  assign run_o     = !(reg_q[STOP_BIT] && (reg_q[DIV_W-1:0] != '0));
  assign sel_err_o = err_q;

  a_r7_src_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(src_o) < NUM_PARENTS);

  a_r5_halt_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && op == OP_HALT) |=> (reg_o[STOP_BIT] && (div_o == '1)));

  a_r8_div_op_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && op == OP_SET_DIV) |=> ((reg_o & ~DIV_MASK) == $past(reg_o & ~DIV_MASK)));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int SRC_W       = 2,
  parameter int NUM_PARENTS = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic [DIV_W-1:0]       div_i,
  input  logic [SRC_W-1:0]       src_i,
  input  logic [NUM_PARENTS-1:0] parent_tick_i,
  output logic                   en_o
);
  logic [DIV_W-1:0] cnt_q, act_div_q, lim;
  logic [SRC_W-1:0] act_src_q, cur_src;
  logic             fresh_q, en_q, sel_tick, hit;

  // first period after a stop uses the live settings
  assign lim     = fresh_q ? div_i : act_div_q;
  assign cur_src = fresh_q ? src_i : act_src_q;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NUM_PARENTS; i++)
      if (cur_src == SRC_W'(i)) sel_tick = parent_tick_i[i];
  end

  assign hit = sel_tick && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_div_q <= '1;
      act_src_q <= '0;
      fresh_q   <= 1'b1;
      en_q      <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
      en_q    <= 1'b0;
    end else begin
      en_q <= hit;
      if (sel_tick) begin
        fresh_q <= 1'b0;
        if (hit) begin
          cnt_q     <= '0;
          act_div_q <= div_i;
          act_src_q <= src_i;
        end else begin
          cnt_q     <= cnt_q + 1'b1;
          act_div_q <= lim;
          act_src_q <= cur_src;
        end
      end
    end
  end

  assign en_o = en_q;

  a_r3_stop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !en_o);

  a_r2_pulse_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> ($past(sel_tick) && $past(run_i)));

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_q |-> (cnt_q <= act_div_q));
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SRC_SHIFT   = 12,
  parameter int SRC_W       = 2,
  parameter int NUM_PARENTS = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [2:0]             op_i,
  input  logic [REG_W-1:0]       wdata_i,
  input  logic [NUM_PARENTS-1:0] parent_tick_i,
  output logic [REG_W-1:0]       rdata_o,
  output logic                   en_o,
  output logic                   sel_err_o
);
  logic [DIV_W-1:0] div;
  logic [SRC_W-1:0] src;
  logic             run;

  clkdiv_regs #(
    .REG_W(REG_W), .SRC_SHIFT(SRC_SHIFT), .SRC_W(SRC_W), .NUM_PARENTS(NUM_PARENTS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .op_i(op_i), .wdata_i(wdata_i),
    .reg_o(rdata_o), .div_o(div), .src_o(src), .run_o(run), .sel_err_o(sel_err_o)
  );

  clkdiv_counter #(
    .SRC_W(SRC_W), .NUM_PARENTS(NUM_PARENTS)
  ) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(div), .src_i(src),
    .parent_tick_i(parent_tick_i), .en_o(en_o)
  );

  a_r4_zero_div_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div == '0 && $past(div) == '0 && $past(run) && parent_tick_i[src] && $past(parent_tick_i[src])
     && src == $past(src)) |=> en_o);
endmodule

// File: tb/clkdiv_chan_bench.sv
module clkdiv_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int RW = 32;
  localparam int WIN = 128;
  localparam int NV = 6;
  localparam int VDIV [NV] = '{0, 1, 2, 5, 9, 63};
  localparam int VEXP [NV] = '{128, 64, 42, 21, 12, 2};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    op = 3'd0;
  logic [RW-1:0] wdata = '0;
  logic [NP-1:0] ptick;
  logic [RW-1:0] rdata;
  logic          en, err;
  logic [7:0]    tcnt = '0;
  int            checks = 0;
  int            fails = 0;
  int            n;

  clkdiv_chan u_clkdiv_chan (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .op_i(op), .wdata_i(wdata),
    .parent_tick_i(ptick), .rdata_o(rdata), .en_o(en), .sel_err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tcnt <= tcnt + 1'b1;
  // parent 0 every cycle, parent 1 every 2nd, parent 2 every 4th
  assign ptick = {tcnt[1:0] == 2'b00, tcnt[0], 1'b1};

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [RW-1:0] d);
    wr_en = 1'b1; op = o; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_pulses(input int w, output int cnt);
    cnt = 0;
    repeat (w) begin
      @(negedge clk);
      cnt += int'(en);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", rdata, 32'h0000_013F);
    check("R1 reset en", RW'(en), 0);
    check("R1 reset err", RW'(err), 0);
    rst_ni = 1'b1;
    count_pulses(20, n);
    check("R3 stopped after reset", n, 0);

    // R2 / R10: ratio table, each run starts from a fresh period
    for (int i = 0; i < NV; i++) begin
      do_op(3'd4, '0);
      do_op(3'd1, RW'(VDIV[i]));
      do_op(3'd3, '0);
      count_pulses(WIN, n);
      check($sformatf("R2 R10 div=%0d pulses", VDIV[i]), n, VEXP[i]);
    end

    // R9: ratio change mid-period waits for period end
    do_op(3'd4, '0);
    do_op(3'd1, 32'd3);
    do_op(3'd3, '0);
    repeat (5) @(negedge clk);
    do_op(3'd1, 32'd0);
    check("R9 no early pulse a", RW'(en), 0);
    @(negedge clk); check("R9 no early pulse b", RW'(en), 0);
    @(negedge clk); check("R9 old period ends", RW'(en), 1);
    @(negedge clk); check("R9 new ratio active", RW'(en), 1);

    // R3: stop with non-zero divide
    do_op(3'd0, 32'h0000_0104);
    count_pulses(40, n);
    check("R3 stop silent", n, 0);

    // R4: stop ignored with zero divide
    do_op(3'd0, 32'h0000_0100);
    check("R4 stop bit stored", rdata, 32'h0000_0100);
    count_pulses(40, n);
    check("R4 zero div keeps running", n, 40);

    // R6: parent selection
    do_op(3'd4, '0);
    do_op(3'd2, 32'd2);
    do_op(3'd1, 32'd0);
    do_op(3'd3, '0);
    count_pulses(64, n);
    check("R6 parent 2 div 0", n, 16);
    do_op(3'd4, '0);
    do_op(3'd2, 32'd1);
    do_op(3'd1, 32'd1);
    do_op(3'd3, '0);
    count_pulses(64, n);
    check("R6 parent 1 div 1", n, 16);

    // R8 / R5: field operations and read-back
    do_op(3'd4, '0);
    do_op(3'd0, 32'hABCD_1105);
    check("R8 full write", rdata, 32'hABCD_1105);
    check("R8 valid write no err", RW'(err), 0);
    do_op(3'd1, 32'hFFFF_FF2A);
    check("R8 set div only", rdata, 32'hABCD_112A);
    do_op(3'd2, 32'h0000_0002);
    check("R8 set parent only", rdata, 32'hABCD_212A);
    do_op(3'd4, '0);
    check("R5 halt forces div", rdata, 32'hABCD_213F);
    do_op(3'd3, '0);
    check("R8 start clears stop", rdata, 32'hABCD_203F);

    // R7: invalid parent index
    do_op(3'd2, 32'd3);
    check("R7 invalid op keeps", rdata, 32'hABCD_203F);
    check("R7 err flagged", RW'(err), 1);
    @(negedge clk);
    check("R7 err one cycle", RW'(err), 0);
    do_op(3'd0, 32'h0000_3005);
    check("R7 full write keeps parent", rdata, 32'h0000_2005);
    check("R7 full write err", RW'(err), 1);

    finish_run();
  end
endmodule